// File: doc/BRIEF.md
# 66B Packet Sequence Validator

This block sits after the stage that unpacks a 513-bit transcoded word into its eight 64B/66B blocks. It takes the eight blocks as one group and checks that, read in order, they describe well-formed packets. It keeps one bit of state: whether the stream is in the gap between packets or inside a packet. That bit carries from one group to the next.

The check is made on the whole group before any of it leaves. A group that passes goes out one block per cycle, block 0 first, unchanged. A group with any block out of order, or one flagged by an external error input from the position checker upstream, goes out as eight error control blocks instead. The sequence state is committed only when a group is accepted. A rejected group sends the state back to the gap.

Alignment markers may appear in either state. They pass through and do not move the state.

Top module: `sqv_seq_validator`

## Requirements
- R1: After reset the block is in the inter-packet gap, `in_ready` is 1 and `out_valid` is 0.
- R2: Block i of a group is `in_group[i*66 +: 66]`. Bits [65:64] of a block are the sync header (01 data, 10 control) and bits [63:56] are the control type. A group that passes comes out unchanged as eight single-block transfers, block 0 first.
- R3: A data block seen while in the gap rejects the group. A rejected group comes out as eight copies of the error control block: sync 10, type 0x1E, then eight 7-bit characters 0x1E.
- R4: A control block of type 0x1E, 0x2D, 0x33, 0x4B, 0x55 or 0x66 seen while inside a packet rejects the group.
- R5: A start block (control type 0x78) seen while inside a packet rejects the group. In the gap, a start block moves the state to in-packet.
- R6: A terminate block (control type 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF) moves the state from in-packet to the gap. Seen while in the gap, it rejects the group.
- R7: A control block whose type is none of those listed in R4, R5 or R6 is an alignment marker. It is accepted in either state, leaves the state unchanged and is forwarded as is.
- R8: The state at the end of an accepted group is the starting state for the next group, and the state changes only when a group is accepted.
- R9: After a rejected group the state is the inter-packet gap.
- R10: When `err_in` is 1 as a group is accepted, that group is rejected even if its blocks are in order.
- R11: A block with sync header 00 or 11 rejects the group.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_block` holds and `in_ready` is 0. A group accepted into an empty block starts coming out on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A group is presented on `in_group` |
| in_ready | output | 1 | The block can take a group this cycle |
| in_group | input | 528 | Eight 66-bit blocks, block 0 in the lowest bits |
| err_in | input | 1 | Position error from upstream for the presented group |
| out_valid | output | 1 | `out_block` holds a block |
| out_ready | input | 1 | Downstream takes `out_block` this cycle |
| out_block | output | 66 | One output block |

## Verification
The sequence check is driven with these groups:
- clean packets that open and close inside one group;
- packets that span a group boundary, which show that the state is carried between groups;
- each class of misordered block, placed in the state where it is illegal;
- groups full of alignment markers in both states, which tell apart transparent markers from markers that change the state;
- bad sync headers;
- the external error flag.

A flagged group of in-packet data followed by a group that opens with a start block shows whether a rejection resets the state or keeps the old state. Holding `out_ready` low shows that the output is held stable and that no new group is taken while one is still going out.

// File: rtl/sqv_pkg.sv
package sqv_pkg;

  localparam int BLK_W  = 66;
  localparam int TYPE_W = 8;
  localparam int HDR_W  = 2 + TYPE_W;

  localparam logic [1:0] SYNC_DATA = 2'b01;
  localparam logic [1:0] SYNC_CTRL = 2'b10;

  // error control block: sync 10, type 0x1E, eight 7-bit error characters
  localparam logic [BLK_W-1:0] ERR_BLOCK = {SYNC_CTRL, 8'h1E, {8{7'h1E}}};

  typedef enum logic [2:0] {
    BK_DATA,
    BK_START,
    BK_TERM,
    BK_CTRL,
    BK_MARK,
    BK_BAD
  } blk_kind_e;

  // sequence state
  typedef enum logic {
    ST_GAP = 1'b0,
    ST_PKT = 1'b1
  } seq_st_e;

endpackage

// File: rtl/sqv_classify.sv
module sqv_classify
  import sqv_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output blk_kind_e        kind
);

  logic [1:0]        sync;
  logic [TYPE_W-1:0] btype;

  assign sync  = hdr[HDR_W-1 -: 2];
  assign btype = hdr[TYPE_W-1:0];

  always_comb begin
    kind = BK_BAD;
    if (sync == SYNC_DATA) begin
      kind = BK_DATA;
    end else if (sync == SYNC_CTRL) begin
      unique case (btype)
        8'h78:                         kind = BK_START;
        8'h87, 8'h99, 8'hAA, 8'hB4,
        8'hCC, 8'hD2, 8'hE1, 8'hFF:    kind = BK_TERM;
        8'h1E, 8'h2D, 8'h33, 8'h4B,
        8'h55, 8'h66:                  kind = BK_CTRL;
        default:                       kind = BK_MARK;
      endcase
    end
  end

endmodule

// File: rtl/sqv_seq_walk.sv
module sqv_seq_walk
  import sqv_pkg::*;
#(
  parameter int GRP_N = 8
) (
  input  blk_kind_e kinds [GRP_N],
  input  seq_st_e   st_start,
  output seq_st_e   st_end,
  output logic      viol
);

  seq_st_e          st_chain [GRP_N+1];
  logic [GRP_N-1:0] viol_vec;

  assign st_chain[0] = st_start;

  for (genvar i = 0; i < GRP_N; i++) begin : g_step
    always_comb begin
      viol_vec[i]     = 1'b0;
      st_chain[i+1]   = st_chain[i];
      unique case (kinds[i])
        BK_DATA:  viol_vec[i] = (st_chain[i] == ST_GAP);
        BK_CTRL:  viol_vec[i] = (st_chain[i] == ST_PKT);
        BK_START: begin
          if (st_chain[i] == ST_PKT) viol_vec[i] = 1'b1;
          else                       st_chain[i+1] = ST_PKT;
        end
        BK_TERM: begin
          if (st_chain[i] == ST_GAP) viol_vec[i] = 1'b1;
          else                       st_chain[i+1] = ST_GAP;
        end
        BK_MARK:  viol_vec[i] = 1'b0;
        default:  viol_vec[i] = 1'b1;
      endcase
    end
  end

  assign st_end = st_chain[GRP_N];
  assign viol   = |viol_vec;

endmodule

// File: rtl/sqv_grp_buf.sv
module sqv_grp_buf
  import sqv_pkg::*;
#(
  parameter int GRP_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             reject,
  input  logic [BLK_W-1:0] blks_in [GRP_N],
  output logic             can_load,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_block
);

  localparam int IDX_W = (GRP_N > 1) ? $clog2(GRP_N) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GRP_N - 1);

  logic [BLK_W-1:0] blk_q [GRP_N];
  logic             full_q, full_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rej_q, rej_d;
  logic             pop, last;

  assign pop      = full_q && out_ready;
  assign last     = (idx_q == IDX_LAST);
  assign can_load = !full_q || (last && out_ready);

  always_comb begin
    full_d = full_q;
    idx_d  = idx_q;
    rej_d  = rej_q;
    if (pop) begin
      if (last) full_d = 1'b0;
      else      idx_d  = idx_q + 1'b1;
    end
    if (load) begin
      full_d = 1'b1;
      idx_d  = '0;
      rej_d  = reject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      rej_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      idx_q  <= idx_d;
      rej_q  <= rej_d;
    end
  end

  for (genvar i = 0; i < GRP_N; i++) begin : g_store
    always_ff @(posedge clk) begin
      if (load) blk_q[i] <= blks_in[i];
    end
  end

  assign out_valid = full_q;
  assign out_block = rej_q ? ERR_BLOCK : blk_q[idx_q];

endmodule

// File: rtl/sqv_seq_validator.sv
module sqv_seq_validator
  import sqv_pkg::*;
#(
  parameter int GRP_N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [GRP_N*BLK_W-1:0] in_group,
  input  logic                   err_in,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [BLK_W-1:0]       out_block
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [BLK_W-1:0] blks  [GRP_N];
  blk_kind_e        kinds [GRP_N];

  for (genvar i = 0; i < GRP_N; i++) begin : g_lane
    assign blks[i] = in_group[i*BLK_W +: BLK_W];
    sqv_classify u_cls (
      .hdr  (blks[i][BLK_W-1 -: HDR_W]),
      .kind (kinds[i])
    );
  end

  seq_st_e state_q, state_d, walk_end;
  logic    viol, reject, accept;

  sqv_seq_walk #(.GRP_N(GRP_N)) u_walk (
    .kinds    (kinds),
    .st_start (state_q),
    .st_end   (walk_end),
    .viol     (viol)
  );

  assign accept = in_valid && in_ready;
  assign reject = viol || err_in;

  always_comb begin
    state_d = state_q;
    if (accept) state_d = reject ? ST_GAP : walk_end;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_GAP;
    else             state_q <= state_d;
  end

  sqv_grp_buf #(.GRP_N(GRP_N)) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (accept),
    .reject    (reject),
    .blks_in   (blks),
    .can_load  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_block (out_block)
  );

endmodule

// File: rtl/sqv_seq_validator_chk.sv
module sqv_seq_validator_chk
  import sqv_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             err_in,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BLK_W-1:0] out_block,
  input logic             state_q
);

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid && !out_ready |=> out_valid && $stable(out_block));

  // R12
  load_to_out_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && in_ready |=> out_valid);

  // R10
  ext_err_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && in_ready && err_in |=> out_block == ERR_BLOCK);

  // R9
  rej_gap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && in_ready && err_in |=> state_q == 1'b0);

  // R8
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(in_valid && in_ready) |=> $stable(state_q));

endmodule

bind sqv_seq_validator sqv_seq_validator_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .err_in     (err_in),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_block  (out_block),
  .state_q    (state_q)
);

// File: tb/tb_sqv_seq_validator.sv
`timescale 1ns/1ps
module tb_sqv_seq_validator;

  localparam int N = 8;
  localparam int W = 66;
  localparam logic [W-1:0] EB = {2'b10, 8'h1E, {8{7'h1E}}};

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic           in_ready;
  logic [N*W-1:0] in_group;
  logic           err_in;
  logic           out_valid;
  logic           out_ready;
  logic [W-1:0]   out_block;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] g [N];

  always #2.5 clk = ~clk;

  sqv_seq_validator dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_group(in_group), .err_in(err_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_block(out_block)
  );

  function automatic logic [W-1:0] dat(input logic [7:0] x);
    return {2'b01, {8{x}}};
  endfunction

  function automatic logic [W-1:0] ctl(input logic [7:0] t);
    return {2'b10, t, 56'h00_0000_0000_0000};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < N; i++) in_group[i*W +: W] = g[i];
    err_in   = e;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    err_in   = 1'b0;
  endtask

  // called at the first negedge after acceptance
  task automatic collect(input string req, input bit pass);
    out_ready = 1'b1;
    for (int k = 0; k < N; k++) begin
      check({req, " valid"}, W'(out_valid), W'(1'b1));
      check(req, out_block, pass ? g[k] : EB);
      @(negedge clk);
    end
  endtask

  task automatic run(input string req, input logic e, input bit pass);
    send(e);
    collect(req, pass);
  endtask

  task automatic t_reset();
    check("R1 in_ready", W'(in_ready), W'(1'b1));
    check("R1 out_valid", W'(out_valid), W'(1'b0));
  endtask

  task automatic t_pass();
    g = '{ctl(8'h78), dat(8'h11), dat(8'h12), dat(8'h13),
          dat(8'h14), dat(8'h15), dat(8'h16), ctl(8'h87)};
    run("R2 clean packet", 1'b0, 1'b1);
    g = '{ctl(8'h1E), ctl(8'h78), dat(8'h21), ctl(8'hFF),
          ctl(8'h78), ctl(8'hCC), ctl(8'h2D), ctl(8'h78)};
    run("R6 terminate closes", 1'b0, 1'b1);
    g = '{ctl(8'hD2), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E),
          ctl(8'h1E), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R6 close carried packet", 1'b0, 1'b1);
  endtask

  task automatic t_carry();
    g = '{ctl(8'h1E), ctl(8'h1E), ctl(8'h78), dat(8'h31),
          dat(8'h32), dat(8'h33), dat(8'h34), dat(8'h35)};
    run("R8 open packet", 1'b0, 1'b1);
    g = '{dat(8'h41), dat(8'h42), ctl(8'hFF), ctl(8'h1E),
          ctl(8'h1E), ctl(8'h1E), ctl(8'h4B), ctl(8'h1E)};
    run("R8 continue packet", 1'b0, 1'b1);
  endtask

  task automatic t_data_gap();
    g = '{ctl(8'h1E), dat(8'h51), ctl(8'h1E), ctl(8'h1E),
          ctl(8'h1E), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R3 data in gap", 1'b0, 1'b0);
  endtask

  task automatic t_ctl_pkt();
    g = '{ctl(8'h78), dat(8'h61), ctl(8'h1E), dat(8'h62),
          ctl(8'h87), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R4 idle in packet", 1'b0, 1'b0);
    // R9: previous reject left the gap, so a fresh start is legal
    g = '{ctl(8'h78), dat(8'h63), dat(8'h64), ctl(8'h66),
          ctl(8'h1E), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R4 ordered set in packet", 1'b0, 1'b0);
  endtask

  task automatic t_start_pkt();
    g = '{ctl(8'h78), dat(8'h71), ctl(8'h78), dat(8'h72),
          ctl(8'hAA), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R5 start in packet", 1'b0, 1'b0);
  endtask

  task automatic t_term_gap();
    g = '{ctl(8'hB4), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E),
          ctl(8'h1E), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R6 terminate in gap", 1'b0, 1'b0);
  endtask

  task automatic t_markers();
    g = '{ctl(8'hC1), ctl(8'h1E), ctl(8'h9D), ctl(8'h78),
          ctl(8'hC1), dat(8'h81), ctl(8'h5A), ctl(8'hE1)};
    run("R7 markers both states", 1'b0, 1'b1);
    g = '{ctl(8'hC1), ctl(8'hC1), ctl(8'hC1), ctl(8'hC1),
          ctl(8'hC1), ctl(8'hC1), ctl(8'hC1), dat(8'h82)};
    run("R7 markers keep gap", 1'b0, 1'b0);
    g = '{ctl(8'h78), ctl(8'hC1), ctl(8'hC1), ctl(8'hC1),
          ctl(8'hC1), ctl(8'hC1), ctl(8'hC1), ctl(8'hC1)};
    run("R7 markers in packet", 1'b0, 1'b1);
    g = '{dat(8'h83), ctl(8'hC1), ctl(8'h99), ctl(8'h1E),
          ctl(8'h1E), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R7 markers keep packet", 1'b0, 1'b1);
  endtask

  task automatic t_ext_err();
    g = '{ctl(8'h78), dat(8'h91), dat(8'h92), dat(8'h93),
          dat(8'h94), dat(8'h95), dat(8'h96), dat(8'h97)};
    run("R10 open packet", 1'b0, 1'b1);
    g = '{dat(8'h98), dat(8'h99), dat(8'h9A), dat(8'h9B),
          dat(8'h9C), dat(8'h9D), dat(8'h9E), dat(8'h9F)};
    run("R10 error input", 1'b1, 1'b0);
    g = '{ctl(8'h78), dat(8'hA1), ctl(8'hFF), ctl(8'h1E),
          ctl(8'h1E), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R9 gap after reject", 1'b0, 1'b1);
  endtask

  task automatic t_bad_sync();
    g = '{ctl(8'h1E), ctl(8'h1E), {2'b00, 64'h0}, ctl(8'h1E),
          ctl(8'h1E), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R11 sync 00", 1'b0, 1'b0);
    g = '{ctl(8'h78), {2'b11, 64'hFFFF_0000_FFFF_0000}, ctl(8'h87), ctl(8'h1E),
          ctl(8'h1E), ctl(8'h1E), ctl(8'h1E), ctl(8'h1E)};
    run("R11 sync 11", 1'b0, 1'b0);
  endtask

  task automatic t_backpressure();
    g = '{ctl(8'h78), dat(8'hB1), dat(8'hB2), dat(8'hB3),
          dat(8'hB4), dat(8'hB5), dat(8'hB6), ctl(8'hE1)};
    out_ready = 1'b0;
    send(1'b0);
    for (int c = 0; c < 3; c++) begin
      check("R12 held valid", W'(out_valid), W'(1'b1));
      check("R12 held block", out_block, g[0]);
      check("R12 in_ready low", W'(in_ready), W'(1'b0));
      @(negedge clk);
    end
    collect("R12 after stall", 1'b1);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    err_in    = 1'b0;
    out_ready = 1'b1;
    in_group  = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pass();
    t_carry();
    t_data_gap();
    t_ctl_pkt();
    t_start_pkt();
    t_term_gap();
    t_markers();
    t_ext_err();
    t_bad_sync();
    t_backpressure();
    repeat (3) @(negedge clk);
    check("R12 drained", W'(out_valid), W'(1'b0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule